// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a 16-bit timer that counts upward from zero on each qualified tick while it is enabled. It restarts when the count reaches a period value. That period is copied from compare register A at the moment counting is switched on. When the count wraps, the block raises a one-cycle period pulse and a one-cycle compare-A pulse. A second compare register, B, raises its own one-cycle pulse when the running count passes through its value.

Software controls the timer through a small byte-addressed register port that accepts byte and halfword writes. A two-byte mode register holds the run and load controls. Reserved bits in the mode register always read as zero, and any write that sets run and load together is rejected. Two 8-bit compare mode registers are stored for neighbouring logic and have no effect inside this block. Reads are combinational on the address.

Top module: `upt_timer`

## Requirements
- R1: After reset every register reads zero, the counter reads zero and all three pulse outputs are low.
- R2: While running, the counter increases by one on each cycle with `cnt_tick_i` high and holds otherwise. While not running it reads zero and ticks have no effect.
- R3: Writing the run bit (bit 7 of the mode high byte) as 1 copies compare A as the period. If compare A is zero, counting does not start. Later writes to compare A do not change the active period.
- R4: On a tick with the count equal to the period, the count becomes zero. `period_uf_o` and `cmpa_hit_o` are then high together for exactly the next cycle.
- R5: On a tick while running with the count equal to compare B, `cmpb_hit_o` is high for exactly the next cycle. No B pulse is issued when B lies above the period.
- R6: Writing the run bit as 0 stops the counter and clears it to zero. Writing it as 1 while running restarts from zero with a freshly copied period.
- R7: A write to the mode high byte with both run (bit 7) and load (bit 6) set is discarded in full. The other byte of the same halfword write is still taken.
- R8: Mode low-byte bits 5, 3 and 2 and mode high-byte bits 2, 1 and 0 are stored as zero and read as zero.
- R9: Address map (byte addresses): 0 = mode low byte, 1 = mode high byte, 2 = counter, 4 = compare A, 6 = compare B, 8 = compare mode A, 9 = compare mode B. Halfword access uses the even address, with the lower byte in data bits 7:0. Byte access at an odd address uses data bits 7:0. The mode register accepts a byte at 0 or 1 and a halfword at 0. A halfword write at 1 is ignored.
- R10: Compare A and B accept byte writes at either of their addresses and halfword writes at the even address. The compare mode registers accept byte writes only. A halfword write at 8 is ignored.
- R11: The counter is read-only. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_tick_i | input | 1 | Count qualifier, one step per high cycle |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_half_i | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr_i | input | 4 | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the current address and size |
| period_uf_o | output | 1 | One-cycle pulse on period wrap |
| cmpa_hit_o | output | 1 | One-cycle pulse on compare A match |
| cmpb_hit_o | output | 1 | One-cycle pulse on compare B match |

## Verification
The bench builds the block with its default 16-bit counter and 4-bit address. It programs very small periods (3 and 5), so many wraps, compare-B hits and restarts fit in a few dozen cycles. Setting B above the period shows that the B pulse never fires in that case. A separate run with gaps in the tick input shows the count holding between ticks.

// File: rtl/upt_pkg.sv
package upt_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int ADDR_W = 4;
  localparam int NUM_CMP = 2;

  // byte addresses of the register port
  localparam logic [ADDR_W-1:0] OFS_MODE  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_CMPA  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CMPB  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_CMODE = 4'h8;

  // writable bits of each mode byte (the rest are reserved)
  localparam logic [BYTE_W-1:0] LO_KEEP = 8'hD3;
  localparam logic [BYTE_W-1:0] HI_KEEP = 8'hF8;
  localparam int RUN_BIT  = 7;
  localparam int LOAD_BIT = 6;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } half_t;
endpackage

// File: rtl/upt_rst_sync.sv
module upt_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/upt_regs.sv
module upt_regs
  import upt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              half_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output half_t             mode_o,
  output logic [HALF_W-1:0] cmpa_o,
  output logic [HALF_W-1:0] cmpb_o,
  output logic [BYTE_W-1:0] cmode_a_o,
  output logic [BYTE_W-1:0] cmode_b_o,
  output logic              arm_o,
  output logic              halt_o
);
  // a lane is selected by a halfword write at its even base, or a byte write at its own address
  function automatic logic lane_sel(input logic [ADDR_W-1:0] a, input logic h,
                                    input logic [ADDR_W-1:0] base, input logic upper);
    if (h) return (a == base);
    return (a == (base | ADDR_W'(upper)));
  endfunction

  logic [BYTE_W-1:0] lane_lo_dat;
  logic [BYTE_W-1:0] lane_hi_dat;
  assign lane_lo_dat = wdata_i[BYTE_W-1:0];
  assign lane_hi_dat = half_i ? wdata_i[HALF_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];

  // ---------------- mode register ----------------
  half_t mode_q, mode_d;
  logic  mlo_we, mhi_we, mhi_ok;

  assign mlo_we = wr_i && lane_sel(addr_i, half_i, OFS_MODE, 1'b0);
  assign mhi_we = wr_i && lane_sel(addr_i, half_i, OFS_MODE, 1'b1);
  assign mhi_ok = mhi_we && !(lane_hi_dat[RUN_BIT] && lane_hi_dat[LOAD_BIT]);

  always_comb begin
    mode_d = mode_q;
    if (mlo_we) mode_d.lo = lane_lo_dat & LO_KEEP;
    if (mhi_ok) mode_d.hi = lane_hi_dat & HI_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mlo_we || mhi_ok) begin
      mode_q <= mode_d;
    end
  end

  // ---------------- compare registers A and B ----------------
  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(OFS_CMPA + 2 * g);
      logic              lo_we, hi_we;
      logic [HALF_W-1:0] val_q, val_d;

      assign lo_we = wr_i && lane_sel(addr_i, half_i, BASE, 1'b0);
      assign hi_we = wr_i && lane_sel(addr_i, half_i, BASE, 1'b1);

      always_comb begin
        val_d = val_q;
        if (lo_we) val_d[BYTE_W-1:0]      = lane_lo_dat;
        if (hi_we) val_d[HALF_W-1:BYTE_W] = lane_hi_dat;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (lo_we || hi_we) begin
          val_q <= val_d;
        end
      end
    end
  endgenerate

  assign cmpa_o = g_cmp[0].val_q;
  assign cmpb_o = g_cmp[1].val_q;

  // ---------------- compare mode registers (byte only) ----------------
  logic              ca_we, cb_we;
  logic [BYTE_W-1:0] cmode_a_q, cmode_b_q;

  assign ca_we = wr_i && !half_i && (addr_i == OFS_CMODE);
  assign cb_we = wr_i && !half_i && (addr_i == (OFS_CMODE | ADDR_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode_a_q <= '0;
      cmode_b_q <= '0;
    end else begin
      if (ca_we) cmode_a_q <= lane_lo_dat;
      if (cb_we) cmode_b_q <= lane_lo_dat;
    end
  end

  // ---------------- run control toward the counter ----------------
  assign arm_o  = mhi_ok && lane_hi_dat[RUN_BIT] && (cmpa_o != '0);
  assign halt_o = mhi_ok && !arm_o;

  assign mode_o    = mode_q;
  assign cmode_a_o = cmode_a_q;
  assign cmode_b_o = cmode_b_q;

  AST_BOTH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mhi_we && lane_hi_dat[RUN_BIT] && lane_hi_dat[LOAD_BIT]) |=> $stable(mode_q.hi)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q.lo & ~LO_KEEP) == '0) && ((mode_q.hi & ~HI_KEEP) == '0)); // R8
  AST_CMODE_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && half_i && (addr_i == OFS_CMODE)) |=> $stable({cmode_a_q, cmode_b_q})); // R10
  AST_MODE_ODD_HALF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && half_i && (addr_i == (OFS_MODE | ADDR_W'(1)))) |=> $stable(mode_q)); // R9
endmodule

// File: rtl/upt_count.sv
module upt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             hitb_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             hitb_q, hitb_d;
  logic             step;

  assign step = run_q && tick_i;

  always_comb begin
    run_d  = run_q;
    per_d  = per_q;
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    hitb_d = 1'b0;
    if (arm_i) begin
      run_d = 1'b1;
      per_d = period_i;
      cnt_d = '0;
    end else if (halt_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (step) begin
      hitb_d = (cnt_q == cmpb_i);
      if (cnt_q == per_q) begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // control state only moves on a command; the count moves on a command or a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= '0;
    end else if (arm_i || halt_i) begin
      run_q <= run_d;
      per_q <= per_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm_i || halt_i || step) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= 1'b0;
      hitb_q <= 1'b0;
    end else begin
      wrap_q <= wrap_d;
      hitb_q <= hitb_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
  assign hitb_o = hitb_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0)); // R2
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q != '0)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= per_q)); // R4
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (cnt_q == '0)); // R4
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q); // R4
  AST_HITB_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    hitb_q |-> $past(run_q)); // R5
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (!run_q && (cnt_q == '0))); // R6
endmodule

// File: rtl/upt_rdmux.sv
module upt_rdmux
  import upt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  input  half_t             mode_i,
  input  logic [HALF_W-1:0] cnt_i,
  input  logic [HALF_W-1:0] cmpa_i,
  input  logic [HALF_W-1:0] cmpb_i,
  input  logic [BYTE_W-1:0] cmode_a_i,
  input  logic [BYTE_W-1:0] cmode_b_i,
  output logic [HALF_W-1:0] rdata_o
);
  logic [HALF_W-1:0] word;

  always_comb begin
    case (addr_i[ADDR_W-1:1])
      OFS_MODE[ADDR_W-1:1]:  word = mode_i;
      OFS_CNT[ADDR_W-1:1]:   word = cnt_i;
      OFS_CMPA[ADDR_W-1:1]:  word = cmpa_i;
      OFS_CMPB[ADDR_W-1:1]:  word = cmpb_i;
      OFS_CMODE[ADDR_W-1:1]: word = {cmode_b_i, cmode_a_i};
      default:               word = '0;
    endcase
  end

  always_comb begin
    if (half_i) begin
      rdata_o = addr_i[0] ? '0 : word;
    end else begin
      rdata_o = {{(HALF_W-BYTE_W){1'b0}},
                 addr_i[0] ? word[HALF_W-1:BYTE_W] : word[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/upt_timer.sv
module upt_timer
  import upt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_half_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              period_uf_o,
  output logic              cmpa_hit_o,
  output logic              cmpb_hit_o
);
  localparam int CNT_W = HALF_W;

  logic              rst_n_s;
  half_t             mode;
  logic [HALF_W-1:0] cmpa, cmpb;
  logic [BYTE_W-1:0] cmode_a, cmode_b;
  logic              arm, halt;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              hitb;

  upt_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  upt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_i      (bus_wr_i),
    .half_i    (bus_half_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .mode_o    (mode),
    .cmpa_o    (cmpa),
    .cmpb_o    (cmpb),
    .cmode_a_o (cmode_a),
    .cmode_b_o (cmode_b),
    .arm_o     (arm),
    .halt_o    (halt)
  );

  upt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (cnt_tick_i),
    .arm_i    (arm),
    .halt_i   (halt),
    .period_i (cmpa),
    .cmpb_i   (cmpb),
    .cnt_o    (cnt),
    .wrap_o   (wrap),
    .hitb_o   (hitb)
  );

  upt_rdmux u_rdmux (
    .addr_i    (bus_addr_i),
    .half_i    (bus_half_i),
    .mode_i    (mode),
    .cnt_i     (cnt),
    .cmpa_i    (cmpa),
    .cmpb_i    (cmpb),
    .cmode_a_i (cmode_a),
    .cmode_b_i (cmode_b),
    .rdata_o   (bus_rdata_o)
  );

  // the period wrap is by definition the compare A match: one flop feeds both pins
  assign period_uf_o = wrap;
  assign cmpa_hit_o  = wrap;
  assign cmpb_hit_o  = hitb;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !(period_uf_o || cmpb_hit_o)); // R1
endmodule

// File: tb/tb_upt_timer.sv
module tb_upt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_tick_i;
  logic        bus_wr_i;
  logic        bus_half_i;
  logic [3:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic        period_uf_o, cmpa_hit_o, cmpb_hit_o;

  always #2 clk = ~clk;

  upt_timer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_tick_i  (cnt_tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_half_i  (bus_half_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .period_uf_o (period_uf_o),
    .cmpa_hit_o  (cmpa_hit_o),
    .cmpb_hit_o  (cmpb_hit_o)
  );

  typedef struct {
    bit          do_rd;
    logic [15:0] rd;
    bit          do_pl;
    logic [2:0]  pl;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [15:0] m_a = 0, m_b = 0, m_per = 0, m_cnt = 0;
  bit m_run = 0, m_uf = 0, m_hb = 0;

  // monitor: pops one expected item per cycle and compares at the falling edge
  always @(negedge clk) begin : mon
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      if (it.do_rd) begin
        checks++;
        if (bus_rdata_o !== it.rd) begin
          errors++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.tag, bus_rdata_o, it.rd);
        end
      end
      if (it.do_pl) begin
        checks++;
        if ({period_uf_o, cmpa_hit_o, cmpb_hit_o} !== it.pl) begin
          errors++;
          $display("FAIL %s: pulses{uf,a,b} actual=%b expected=%b", it.tag,
                   {period_uf_o, cmpa_hit_o, cmpb_hit_o}, it.pl);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input bit h, input logic [15:0] d);
    logic [7:0] hb;
    @(posedge clk); #1;
    cnt_tick_i = 0; bus_wr_i = 1; bus_half_i = h; bus_addr_i = a; bus_wdata_i = d;
    if (h ? (a == 4'h0) : (a == 4'h1)) begin
      hb = h ? d[15:8] : d[7:0];
      if (!(hb[7] && hb[6])) begin
        if (hb[7] && m_a != 0) begin m_run = 1; m_per = m_a; end
        else m_run = 0;
        m_cnt = 0;
      end
    end
    if (h && a == 4'h4) m_a = d;
    else if (!h && a == 4'h4) m_a[7:0] = d[7:0];
    else if (!h && a == 4'h5) m_a[15:8] = d[7:0];
    if (h && a == 4'h6) m_b = d;
    else if (!h && a == 4'h6) m_b[7:0] = d[7:0];
    else if (!h && a == 4'h7) m_b[15:8] = d[7:0];
    m_uf = 0; m_hb = 0;
  endtask

  task automatic rd(input logic [3:0] a, input bit h, input logic [15:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    cnt_tick_i = 0; bus_wr_i = 0; bus_half_i = h; bus_addr_i = a;
    it.do_rd = 1; it.rd = exp; it.do_pl = 0; it.pl = 0; it.tag = tag;
    q.push_back(it);
    m_uf = 0; m_hb = 0;
  endtask

  // one cycle reading the counter and checking pulses, with the given tick
  task automatic run(input bit t, input string tag);
    item_t it;
    @(posedge clk); #1;
    cnt_tick_i = t; bus_wr_i = 0; bus_half_i = 1; bus_addr_i = 4'h2;
    it.do_rd = 1; it.rd = m_cnt; it.do_pl = 1; it.pl = {m_uf, m_uf, m_hb}; it.tag = tag;
    q.push_back(it);
    if (m_run && t) begin
      m_hb = (m_cnt == m_b);
      m_uf = (m_cnt == m_per);
      m_cnt = m_uf ? 16'h0 : m_cnt + 1;
    end else begin
      m_uf = 0; m_hb = 0;
    end
  endtask

  initial begin
    rst_n = 0; cnt_tick_i = 0; bus_wr_i = 0; bus_half_i = 0; bus_addr_i = 0; bus_wdata_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    // R1 reset state
    rd(4'h0, 1, 16'h0000, "R1");
    rd(4'h2, 1, 16'h0000, "R1");
    rd(4'h4, 1, 16'h0000, "R1");
    rd(4'h6, 1, 16'h0000, "R1");
    rd(4'h8, 1, 16'h0000, "R1");
    run(0, "R1");
    // R8 reserved bits, R9 byte and halfword views
    wr(4'h0, 0, 16'h00FF);
    wr(4'h1, 0, 16'h003F);
    rd(4'h0, 1, 16'h38D3, "R8");
    rd(4'h1, 0, 16'h0038, "R9");
    rd(4'h0, 0, 16'h00D3, "R9");
    // R7 run+load rejected
    wr(4'h1, 0, 16'h00C0);
    rd(4'h1, 0, 16'h0038, "R7");
    wr(4'h0, 1, 16'hC000);
    rd(4'h0, 1, 16'h3800, "R7");
    // R9 halfword at odd mode address ignored
    wr(4'h1, 1, 16'h1234);
    rd(4'h0, 1, 16'h3800, "R9");
    // R3 enable with compare A zero does not count
    wr(4'h1, 0, 16'h0080);
    repeat (4) run(1, "R3");
    wr(4'h1, 0, 16'h0000);
    // R10 compare registers
    wr(4'h4, 0, 16'h0003);
    wr(4'h5, 0, 16'h0000);
    wr(4'h6, 1, 16'h0001);
    rd(4'h4, 1, 16'h0003, "R10");
    rd(4'h6, 1, 16'h0001, "R10");
    wr(4'h8, 0, 16'h005A);
    wr(4'h9, 0, 16'h00A5);
    wr(4'h8, 1, 16'hFFFF);
    rd(4'h8, 1, 16'hA55A, "R10");
    rd(4'h9, 0, 16'h00A5, "R10");
    // R11 counter write ignored
    wr(4'h2, 1, 16'h1234);
    rd(4'h2, 1, 16'h0000, "R11");
    // R2 R4 R5 counting with period 3, B 1
    wr(4'h1, 0, 16'h0080);
    repeat (10) run(1, "R4");
    run(0, "R2"); run(0, "R2"); run(1, "R2"); run(0, "R2");
    repeat (4) run(1, "R5");
    // R3 new A value does not change active period
    wr(4'h5, 0, 16'h0001);
    rd(4'h4, 1, 16'h0103, "R10");
    wr(4'h4, 1, 16'h0005);
    rd(4'h5, 0, 16'h0000, "R10");
    repeat (8) run(1, "R3");
    // R6 restart picks up period 5
    wr(4'h1, 0, 16'h0080);
    repeat (14) run(1, "R6");
    // R5 B above period never pulses
    wr(4'h6, 1, 16'h0009);
    repeat (8) run(1, "R5");
    // R6 stop clears and ignores ticks
    wr(4'h1, 0, 16'h0000);
    repeat (4) run(1, "R6");
    rd(4'h1, 0, 16'h0000, "R6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule